// File: doc/BRIEF.md
# Wired-to-Message Interrupt Bridge

The bridge takes a group of wired interrupt lines from devices and turns each assertion into one message write toward a downstream translator that only understands single events. Every line has its own three-state tracker: idle, pending, and pending-and-active. A line enters pending when its trigger fires and is offered on the message port. Once the message has been taken, the line waits in pending-and-active. It returns to idle when its level falls (level lines only) or when software writes end-of-interrupt for it.

Software uses a small register port to pick each line's trigger type and to issue end-of-interrupt. A read port returns the per-line states and the trigger bitmap. When several lines are pending, a round-robin arbiter chooses which one drives the message port. The port uses a valid/ready handshake that carries the line index.

Top module: `irq_msg_bridge`

## Requirements
- R1: After reset every line is idle (status 00), every line is level-triggered (trigger bitmap all 0), and msg_valid_o is low.
- R2: A level line whose input goes high reaches pending three clock edges after the input change: two edges of synchronization and one edge of state update. While the line is pending, msg_valid_o is high with msg_idx_o equal to the line.
- R3: A line moves from pending to pending-and-active only on a cycle with both msg_valid_o and msg_ready_i high for its index. While pending-and-active it is never offered again, so a level held high yields exactly one message.
- R4: A level line in pending-and-active returns to idle once its synchronized input is low.
- R5: An end-of-interrupt write (address 2, line index in wr_data_i[IDX_W-1:0]) returns a pending-and-active line to idle. If a level line is still high afterwards, it re-enters pending and sends a fresh message.
- R6: An end-of-interrupt write to an idle or pending line has no effect. A pending line keeps its owed message.
- R7: An edge line leaves idle only on a rising edge of its synchronized input. An input that stays high across end-of-interrupt sends no further message.
- R8: A trigger write (address 1, line index in wr_data_i[IDX_W-1:0], type code in wr_data_i[17:16]) sets level on code 01 and rising edge on code 10. Codes 00 and 11 are rejected and leave the type unchanged. Reading address 1 returns the bitmap, with 1 meaning edge.
- R9: After a message for line i, the next grant goes to the first pending line found searching cyclically from i+1.
- R10: While msg_valid_o is high and msg_ready_i is low, msg_valid_o stays high and msg_idx_o stays stable, even if other lines become pending.
- R11: Reading address 0 returns line k's state in bits [2k+1:2k]: 00 idle, 01 pending, 11 pending-and-active. The code 10 never appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| irq_i | input | N_LINES | Wired interrupt lines, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | ADDR_W | Register read address |
| rd_data_o | output | DATA_W | Register read data (combinational) |
| msg_valid_o | output | 1 | Message offered |
| msg_ready_i | input | 1 | Downstream accepts message |
| msg_idx_o | output | IDX_W | Index of the line being sent |

## Verification
Two routes back to idle can land on the same edge: a level line's synchronized input falling, and an end-of-interrupt write for that line. The bench provokes this by dropping the line and then presenting the write in the cycle just after the second synchronizer edge, so both conditions reach the tracker together. It judges the result by reading status 00 and seeing no extra message. It also times a new pending line to arrive while a message is stalled. The offered index must not move.

// File: rtl/irq_bridge_pkg.sv
package irq_bridge_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_PEND = 2'b01,
    ST_ACT  = 2'b11
  } line_st_e;

  localparam int unsigned REG_STATUS = 0;
  localparam int unsigned REG_TRIG   = 1;
  localparam int unsigned REG_EOI    = 2;

  localparam logic [1:0] TYPE_LEVEL = 2'b01;
  localparam logic [1:0] TYPE_EDGE  = 2'b10;
  localparam int unsigned TYPE_LSB  = 16;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned N_LINES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] async_i,
  output logic [N_LINES-1:0] lvl_o,
  output logic [N_LINES-1:0] prev_o
);
  logic [N_LINES-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= async_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign lvl_o  = s2_q;
  assign prev_o = s3_q;
endmodule

// File: rtl/irq_line_fsm.sv
module irq_line_fsm
  import irq_bridge_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     edge_mode_i,
  input  logic     lvl_i,
  input  logic     prev_i,
  input  logic     send_i,
  input  logic     eoi_i,
  output line_st_e state_o
);
  line_st_e st_q, st_d;
  logic     trig;

  assign trig = edge_mode_i ? (lvl_i & ~prev_i) : lvl_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (trig) st_d = ST_PEND;
      ST_PEND: if (send_i) st_d = ST_ACT;     // eoi ignored: message still owed
      ST_ACT:  if (eoi_i || (!edge_mode_i && !lvl_i)) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign state_o = st_q;
endmodule

// File: rtl/irq_rr_arb.sv
module irq_rr_arb #(
  parameter int unsigned N_LINES = 8,
  localparam int unsigned IDX_W  = $clog2(N_LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] req_i,
  input  logic               ready_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [N_LINES-1:0] grant_o
);
  logic [IDX_W-1:0] ptr_q, lock_idx_q, pick;
  logic             lock_q, found;
  logic [IDX_W:0]   cand;

  always_comb begin
    pick  = ptr_q;
    found = 1'b0;
    cand  = '0;
    for (int k = 0; k < N_LINES; k++) begin
      cand = {1'b0, ptr_q} + (IDX_W+1)'(k);
      if (cand >= (IDX_W+1)'(N_LINES)) cand = cand - (IDX_W+1)'(N_LINES);
      if (!found && req_i[cand[IDX_W-1:0]]) begin
        found = 1'b1;
        pick  = cand[IDX_W-1:0];
      end
    end
  end

  assign valid_o = |req_i;
  // a stalled offer keeps its index until taken
  assign idx_o   = lock_q ? lock_idx_q : pick;

  always_comb begin
    grant_o = '0;
    if (valid_o && ready_i) grant_o[idx_o] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q      <= '0;
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
    end else begin
      lock_q     <= valid_o & ~ready_i;
      lock_idx_q <= idx_o;
      if (valid_o && ready_i)
        ptr_q <= (idx_o == IDX_W'(N_LINES-1)) ? '0 : idx_o + 1'b1;
    end
  end
endmodule

// File: rtl/irq_msg_bridge.sv
module irq_msg_bridge
  import irq_bridge_pkg::*;
#(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned IDX_W  = $clog2(N_LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] irq_i,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic [DATA_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0]  rd_data_o,
  output logic               msg_valid_o,
  input  logic               msg_ready_i,
  output logic [IDX_W-1:0]   msg_idx_o
);
  logic [N_LINES-1:0]   lvl_sync, lvl_prev, edge_q, eoi_vec, send_vec, pend_vec;
  logic [2*N_LINES-1:0] st_flat;
  logic [IDX_W-1:0]     wr_line;
  logic                 wr_line_ok;
  logic [1:0]           wr_type;

  assign wr_line    = wr_data_i[IDX_W-1:0];
  assign wr_line_ok = (int'(wr_line) < N_LINES);
  assign wr_type    = wr_data_i[TYPE_LSB +: 2];

  irq_sync #(.N_LINES(N_LINES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(irq_i),
    .lvl_o  (lvl_sync),
    .prev_o (lvl_prev)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edge_q <= '0;
    end else if (wr_en_i && wr_addr_i == ADDR_W'(REG_TRIG) && wr_line_ok) begin
      if (wr_type == TYPE_EDGE)       edge_q[wr_line] <= 1'b1;
      else if (wr_type == TYPE_LEVEL) edge_q[wr_line] <= 1'b0;
    end
  end

  always_comb begin
    eoi_vec = '0;
    if (wr_en_i && wr_addr_i == ADDR_W'(REG_EOI) && wr_line_ok) eoi_vec[wr_line] = 1'b1;
  end

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    line_st_e st;
    irq_line_fsm u_fsm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .edge_mode_i(edge_q[g]),
      .lvl_i      (lvl_sync[g]),
      .prev_i     (lvl_prev[g]),
      .send_i     (send_vec[g]),
      .eoi_i      (eoi_vec[g]),
      .state_o    (st)
    );
    assign st_flat[2*g +: 2] = st;
    assign pend_vec[g]       = (st == ST_PEND);
  end

  irq_rr_arb #(.N_LINES(N_LINES)) u_arb (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (pend_vec),
    .ready_i(msg_ready_i),
    .valid_o(msg_valid_o),
    .idx_o  (msg_idx_o),
    .grant_o(send_vec)
  );

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == ADDR_W'(REG_STATUS))    rd_data_o[2*N_LINES-1:0] = st_flat;
    else if (rd_addr_i == ADDR_W'(REG_TRIG)) rd_data_o[N_LINES-1:0]   = edge_q;
  end
endmodule

// File: rtl/irq_bridge_chk.sv
module irq_bridge_chk #(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned IDX_W   = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 valid_i,
  input logic                 ready_i,
  input logic [IDX_W-1:0]     idx_i,
  input logic [2*N_LINES-1:0] st_i,
  input logic [N_LINES-1:0]   lvl_i,
  input logic [N_LINES-1:0]   edge_i
);
  // R10
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !ready_i) |=> (valid_i && $stable(idx_i)));

  // R3
  offer_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (st_i[2*idx_i +: 2] == 2'b01));

  // R3
  post_send_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_i) |=> (st_i[2*$past(idx_i) +: 2] == 2'b11));

  for (genvar g = 0; g < N_LINES; g++) begin : g_chk
    // R4
    level_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!edge_i[g] && st_i[2*g +: 2] == 2'b11 && !lvl_i[g]) |=> (st_i[2*g +: 2] == 2'b00));

    // R11
    enc_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      st_i[2*g +: 2] != 2'b10);

    // R3
    no_resend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_i[2*g +: 2] == 2'b11) |-> !(valid_i && idx_i == IDX_W'(g)));
  end
endmodule

bind irq_msg_bridge irq_bridge_chk #(.N_LINES(N_LINES), .IDX_W(IDX_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(msg_valid_o),
  .ready_i(msg_ready_i),
  .idx_i  (msg_idx_o),
  .st_i   (st_flat),
  .lvl_i  (lvl_sync),
  .edge_i (edge_q)
);

// File: tb/sim_irq_msg_bridge.sv
`timescale 1ns/1ps
module sim_irq_msg_bridge;
  localparam int N = 8;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  irq = '0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          valid;
  logic          ready = 1'b1;
  logic [IW-1:0] idx;

  int total = 0;
  int bad = 0;
  int cnt [N];

  always #4 clk = ~clk;

  irq_msg_bridge #(.N_LINES(N), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .msg_valid_o(valid), .msg_ready_i(ready), .msg_idx_o(idx)
  );

  // handshake monitor, 1 ns before the rising edge
  initial for (int i = 0; i < N; i++) cnt[i] = 0;
  always @(negedge clk) begin
    #3;
    if (rst_n && valid && ready) cnt[idx] = cnt[idx] + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    rd_addr = AW'(a);
    #1;
    d = int'(rd_data);
  endtask

  function automatic int st_of(input int word, input int line);
    return (word >> (2*line)) & 3;
  endfunction

  task automatic t_reset();
    int d;
    rd(0, d); check(d == 0, "R1 status", d, 0);
    rd(1, d); check(d == 0, "R1 trig", d, 0);
    check(valid == 0, "R1 valid", valid, 0);
  endtask

  task automatic t_level_basic();
    int d;
    @(negedge clk); irq[2] = 1'b1;
    cyc(2); check(valid == 0, "R2 not yet", valid, 0);
    cyc(1);
    check(valid == 1 && idx == 2, "R2 offer", idx, 2);
    rd(0, d); check(st_of(d, 2) == 1, "R11 pending code", st_of(d, 2), 1);
    cyc(1);
    rd(0, d); check(st_of(d, 2) == 3, "R11 active code", st_of(d, 2), 3);
    cyc(10);
    check(cnt[2] == 1, "R3 one message", cnt[2], 1);
    irq[2] = 1'b0;
    cyc(4);
    rd(0, d); check(st_of(d, 2) == 0, "R4 level fall", st_of(d, 2), 0);
    check(cnt[2] == 1, "R4 no extra", cnt[2], 1);
  endtask

  task automatic t_eoi();
    int d;
    @(negedge clk); irq[3] = 1'b1;
    cyc(6);
    check(cnt[3] == 1, "R5 first msg", cnt[3], 1);
    wr(2, 3);
    cyc(6);
    check(cnt[3] == 2, "R5 refire", cnt[3], 2);
    rd(0, d); check(st_of(d, 3) == 3, "R5 active again", st_of(d, 3), 3);
    irq[3] = 1'b0;
    cyc(4);
    wr(2, 3);
    cyc(3);
    rd(0, d); check(st_of(d, 3) == 0, "R6 eoi on idle", st_of(d, 3), 0);
    check(cnt[3] == 2, "R6 no msg", cnt[3], 2);
    // eoi on pending line
    ready = 1'b0;
    irq[4] = 1'b1;
    cyc(5);
    rd(0, d); check(st_of(d, 4) == 1, "R6 pending", st_of(d, 4), 1);
    wr(2, 4);
    cyc(2);
    rd(0, d); check(st_of(d, 4) == 1, "R6 eoi on pending", st_of(d, 4), 1);
    check(valid == 1 && idx == 4, "R10 held offer", idx, 4);
    ready = 1'b1;
    cyc(3);
    check(cnt[4] == 1, "R6 owed msg sent", cnt[4], 1);
    irq[4] = 1'b0;
    cyc(4);
  endtask

  task automatic t_cfg_edge();
    int d;
    wr(1, (2 << 16) | 5);
    rd(1, d); check(((d >> 5) & 1) == 1, "R8 set edge", (d >> 5) & 1, 1);
    wr(1, (3 << 16) | 5);
    wr(1, (0 << 16) | 5);
    rd(1, d); check(((d >> 5) & 1) == 1, "R8 reject codes", (d >> 5) & 1, 1);
    wr(1, (1 << 16) | 6);
    rd(1, d); check(d == 32'h20, "R8 level bitmap", d, 32'h20);
    irq[5] = 1'b1;
    cyc(6);
    check(cnt[5] == 1, "R7 edge msg", cnt[5], 1);
    wr(2, 5);
    cyc(6);
    rd(0, d); check(st_of(d, 5) == 0, "R7 held high idle", st_of(d, 5), 0);
    check(cnt[5] == 1, "R7 no msg on held high", cnt[5], 1);
    irq[5] = 1'b0;
    cyc(3);
    irq[5] = 1'b1;
    cyc(6);
    check(cnt[5] == 2, "R7 second edge", cnt[5], 2);
    wr(2, 5);
    irq[5] = 1'b0;
    wr(1, (1 << 16) | 5);
    rd(1, d); check(d == 0, "R8 back to level", d, 0);
    cyc(3);
  endtask

  task automatic t_rr();
    // last grant was line 5
    ready = 1'b0;
    @(negedge clk); irq[1] = 1'b1; irq[3] = 1'b1; irq[6] = 1'b1;
    cyc(5);
    check(valid && idx == 6, "R9 first after 5", idx, 6);
    ready = 1'b1; @(negedge clk); ready = 1'b0;
    check(valid && idx == 1, "R9 wrap to 1", idx, 1);
    irq[7] = 1'b1;
    cyc(5);
    check(valid && idx == 1, "R10 stable under new req", idx, 1);
    ready = 1'b1; @(negedge clk); ready = 1'b0;
    check(valid && idx == 3, "R9 next 3", idx, 3);
    ready = 1'b1; @(negedge clk); ready = 1'b0;
    check(valid && idx == 7, "R9 next 7", idx, 7);
    ready = 1'b1;
    cyc(2);
    check(cnt[7] == 1 && cnt[6] == 1, "R9 all sent", cnt[7], 1);
    irq = '0;
    cyc(4);
  endtask

  task automatic t_same_cycle();
    int d;
    int c0;
    @(negedge clk); irq[0] = 1'b1;
    cyc(6);
    c0 = cnt[0];
    check(c0 == 1, "R3 line0 msg", c0, 1);
    irq[0] = 1'b0;
    @(posedge clk); @(posedge clk);
    wr(2, 0);   // eoi lands with the synchronized fall
    cyc(6);
    rd(0, d); check(st_of(d, 0) == 0, "R4 R5 joint clear", st_of(d, 0), 0);
    check(cnt[0] == c0, "R5 no extra on joint", cnt[0], c0);
    check(valid == 0, "R4 idle bus", valid, 0);
  endtask

  initial begin
    #(8 * 100000);
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(2);
    t_reset();
    t_level_basic();
    t_eoi();
    t_cfg_edge();
    t_rr();
    t_same_cycle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule